// File: doc/BRIEF.md
# Signed ppm Second-Rate Trimmer

This block turns a crystal-rate count enable (nominally 32768 per second) into a one-cycle pulse once per second. It also applies a small signed frequency correction. The correction works by making chosen seconds one input count shorter or one count longer. The total adjustment per averaging window therefore matches the requested ppm value.

A 3-bit trim value sets the correction. One bit is the direction and two binary-weighted bits are the magnitude, in steps of 10 ppm, so the range is -30 ppm to +30 ppm. Over a fixed window of `WINDOW_COUNTS` enables (default 100,000), the block schedules N = ppm/10 whole-count corrections. It applies at most one correction at each second boundary. Any correction still owed is carried forward.

A new trim value is staged when written. It becomes active only at the next window boundary, and the running second is never disturbed.

The parameters must satisfy `WINDOW_COUNTS >= 3*(SEC_COUNTS+1)`. This guarantees that every window holds enough second boundaries to apply a full window's corrections.

Top module: `ppm_second_trimmer`

## Requirements
- R1: A synchronous active-high reset clears the prescaler, the window counter, the pending corrections and both trim registers, and holds `tick_1hz` low. The first second after reset lasts exactly `SEC_COUNTS` enables.
- R2: `tick_1hz` is high for exactly one clock cycle. That cycle is the one after the clock edge that accepts the last enable of a second.
- R3: A cycle with `cnt_en` low does not advance any counter. The next cycle has `tick_1hz` low.
- R4: Trim encoding: bit 2 is the direction (0 = speed up, 1 = slow down), bit 1 weighs 10 ppm and bit 0 weighs 20 ppm. The number of corrections per window is N = bit1 + 2*bit0.
- R5: With direction 0, each corrected second lasts `SEC_COUNTS-1` enables.
- R6: With direction 1, each corrected second lasts `SEC_COUNTS+1` enables.
- R7: With magnitude 0, every second lasts exactly `SEC_COUNTS` enables, whichever direction is selected.
- R8: At most one correction is applied per second. Corrections are applied at the earliest second boundaries after their window boundary. None is still owed when the following window ends.
- R9: A trim write is staged only. Second lengths keep following the previous active trim until the next window boundary, which is the edge accepting the `WINDOW_COUNTS`-th enable of a window.
- R10: Every second lasts `SEC_COUNTS-1`, `SEC_COUNTS` or `SEC_COUNTS+1` enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Crystal-rate count enable, one input count per high cycle |
| trim_wr | input | 1 | Write strobe for the trim value |
| trim_wdata | input | 3 | Trim value: [2] direction, [1] 10 ppm, [0] 20 ppm |
| tick_1hz | output | 1 | One-cycle pulse at the end of each second |

## Verification
A wrong prescaler count or a wrong selected length shows up as a tick that is early or late by at least one enable. It appears at the very next second boundary. A fault in the staged or active trim, or in the pending-correction counter, stays hidden until the next window boundary. It then shows within the following three seconds, as a missing, extra or wrongly signed one-count correction. The bench therefore compares every cycle's tick against a cycle-exact model. It also checks each completed second's length, across many windows, trim changes and gaps in the enable.

// File: rtl/ppm_trim_pkg.sv
package ppm_trim_pkg;

    // Trim value layout: [2] direction, [1] 10 ppm, [0] 20 ppm
    typedef struct packed {
        logic slow;     // 1 = lengthen seconds (negative correction)
        logic ten;      // 10 ppm weight
        logic twenty;   // 20 ppm weight
    } trim_t;

    // Width of the pending-correction counter
    localparam int CORR_W = 3;

    // Which length the running second uses
    typedef enum logic [1:0] {
        LEN_NOM   = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_LONG  = 2'd2
    } len_sel_e;

    // Whole-count corrections per window: 10 ppm -> 1, 20 ppm -> 2
    function automatic logic [CORR_W-1:0] corr_count(input trim_t t);
        return {1'b0, t.twenty, t.ten};
    endfunction

endpackage

// File: rtl/trim_stage_reg.sv
module trim_stage_reg
    import ppm_trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  trim_t wr_data,
    input  logic  win_end,
    output trim_t staged,
    output trim_t active
);

    trim_t staged_q;
    trim_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en)
                staged_q <= wr_data;
            if (win_end)
                active_q <= staged_q;
        end
    end

    assign staged = staged_q;
    assign active = active_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(active_q)); // R9

endmodule

// File: rtl/corr_window_sched.sv
module corr_window_sched
    import ppm_trim_pkg::*;
#(
    parameter int WINDOW_COUNTS = 100000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cnt_en,
    input  logic  sec_end,
    input  trim_t staged,
    output logic  win_end,
    output logic  adj_req
);

    localparam int WIN_W = $clog2(WINDOW_COUNTS);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_COUNTS - 1);

    logic [WIN_W-1:0]  win_q;
    logic [CORR_W-1:0] pend_q;
    logic [CORR_W-1:0] pend_nxt;
    logic              take;

    assign win_end = cnt_en && (win_q == WIN_LAST);
    assign adj_req = (pend_q != '0);
    assign take    = sec_end && adj_req;

    always_comb begin
        pend_nxt = pend_q - CORR_W'(take);
        if (win_end)
            pend_nxt = pend_nxt + corr_count(staged);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            pend_q <= '0;
        end else begin
            if (cnt_en)
                win_q <= win_end ? '0 : win_q + 1'b1;
            pend_q <= pend_nxt;
        end
    end

    AST_WINDOW_DRAINED: assert property (@(posedge clk) disable iff (rst)
        win_end |-> (pend_q - CORR_W'(take)) == '0); // R8

    AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (rst)
        pend_q <= CORR_W'(3)); // R8

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import ppm_trim_pkg::*;
#(
    parameter int SEC_COUNTS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_en,
    input  logic adj_req,
    input  logic adj_slow,
    output logic sec_end,
    output logic tick
);

    localparam int PS_W = $clog2(SEC_COUNTS + 2);

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] cur_len;
    len_sel_e        sel_q;
    len_sel_e        sel_nxt;
    logic            tick_q;

    always_comb begin
        case (sel_q)
            LEN_SHORT: cur_len = PS_W'(SEC_COUNTS - 1);
            LEN_LONG:  cur_len = PS_W'(SEC_COUNTS + 1);
            default:   cur_len = PS_W'(SEC_COUNTS);
        endcase
    end

    assign sec_end = cnt_en && (ps_q == cur_len - 1'b1);
    assign sel_nxt = !adj_req ? LEN_NOM : (adj_slow ? LEN_LONG : LEN_SHORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q   <= '0;
            sel_q  <= LEN_NOM;
            tick_q <= 1'b0;
        end else begin
            tick_q <= sec_end;
            if (cnt_en) begin
                if (sec_end) begin
                    ps_q  <= '0;
                    sel_q <= sel_nxt;
                end else begin
                    ps_q <= ps_q + 1'b1;
                end
            end
        end
    end

    assign tick = tick_q;

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q); // R2

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> !tick_q); // R3

    AST_COUNT_IN_SECOND: assert property (@(posedge clk) disable iff (rst)
        ps_q < cur_len); // R10

    AST_LEN_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sel_q != 2'd3); // R10

endmodule

// File: rtl/ppm_second_trimmer.sv
module ppm_second_trimmer
    import ppm_trim_pkg::*;
#(
    parameter int SEC_COUNTS    = 32768,
    parameter int WINDOW_COUNTS = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       trim_wr,
    input  logic [2:0] trim_wdata,
    output logic       tick_1hz
);

    trim_t staged;
    trim_t active;
    logic  win_end;
    logic  sec_end;
    logic  adj_req;

    trim_stage_reg u_trim (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (trim_wr),
        .wr_data (trim_t'(trim_wdata)),
        .win_end (win_end),
        .staged  (staged),
        .active  (active)
    );

    corr_window_sched #(.WINDOW_COUNTS(WINDOW_COUNTS)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .sec_end (sec_end),
        .staged  (staged),
        .win_end (win_end),
        .adj_req (adj_req)
    );

    sec_prescaler #(.SEC_COUNTS(SEC_COUNTS)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .adj_req  (adj_req),
        .adj_slow (active.slow),
        .sec_end  (sec_end),
        .tick     (tick_1hz)
    );

endmodule

// File: tb/ppm_second_trimmer_tb.sv
module ppm_second_trimmer_tb;

    localparam int S = 64;
    localparam int W = 200;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic       trim_wr;
    logic [2:0] trim_wdata;
    logic       tick_1hz;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int       m_p, m_len, m_w, m_pend, meas;
    logic [2:0] m_shadow, m_active;
    bit       m_first, m_len_zero;

    always #10 clk = ~clk;

    ppm_second_trimmer #(.SEC_COUNTS(S), .WINDOW_COUNTS(W)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .trim_wr(trim_wr), .trim_wdata(trim_wdata), .tick_1hz(tick_1hz)
    );

    function automatic int n_of(input logic [2:0] t);
        return int'(t[1]) + 2 * int'(t[0]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic e, input logic w, input logic [2:0] d, input logic r);
        bit exp_tick = 0;
        int done_len = 0;
        bit done_zero = 0;
        if (r) begin
            m_p = 0; m_len = S; m_w = 0; m_pend = 0;
            m_shadow = '0; m_active = '0; meas = 0;
            m_first = 1; m_len_zero = 1;
            check(tick_1hz == 1'b0, "R1 tick low in reset", int'(tick_1hz), 0);
            return;
        end
        if (e) begin
            bit sec_end = (m_p == m_len - 1);
            bit win_end = (m_w == W - 1);
            bit take    = sec_end && (m_pend != 0);
            meas++;
            if (sec_end) begin
                exp_tick  = 1;
                done_len  = m_len;
                done_zero = m_len_zero;
                m_p = 0;
                m_len_zero = (m_active[1:0] == 2'b00);
                m_len = (m_pend != 0) ? (m_active[2] ? S + 1 : S - 1) : S;
            end else begin
                m_p++;
            end
            m_pend -= int'(take);
            if (win_end) begin
                m_w = 0;
                m_pend += n_of(m_shadow);
                m_active = m_shadow;
            end else begin
                m_w++;
            end
        end
        if (w) m_shadow = d;

        check(tick_1hz == exp_tick, "R2 tick timing", int'(tick_1hz), int'(exp_tick));
        if (!e)
            check(tick_1hz == 1'b0, "R3 idle cycle gives no tick", int'(tick_1hz), 0);
        if (exp_tick && tick_1hz) begin
            check(meas == done_len, "R4/R8 second length", meas, done_len);
            check(meas >= S - 1 && meas <= S + 1, "R10 length range", meas, S);
            if (m_first)          check(meas == S, "R1 first second", meas, S);
            if (done_len == S - 1) check(meas == S - 1, "R5 shortened second", meas, S - 1);
            if (done_len == S + 1) check(meas == S + 1, "R6 lengthened second", meas, S + 1);
            if (done_zero)        check(meas == S, "R7 zero magnitude", meas, S);
            if (m_shadow != m_active) check(meas == done_len, "R9 staged trim not yet used", meas, done_len);
            m_first = 0;
        end
        if (tick_1hz) meas = 0;
    endtask

    task automatic cyc(input logic e, input logic w, input logic [2:0] d, input logic r);
        rst = r; cnt_en = e; trim_wr = w; trim_wdata = d;
        @(negedge clk);
        model_step(e, w, d, r);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2024);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 3'b000, 1'b1);
        // directed: +30, then -10, then negative zero, with a mid-run reset
        for (int i = 0; i < 3000; i++) begin
            if (i == 0)         cyc(1'b1, 1'b1, 3'b011, 1'b0);
            else if (i == 1000) cyc(1'b1, 1'b1, 3'b110, 1'b0);
            else if (i == 1800) cyc(1'b1, 1'b1, 3'b100, 1'b0);
            else if (i == 2400) cyc(1'b1, 1'b1, 3'b101, 1'b0);
            else if (i == 2600 || i == 2601) cyc(1'b1, 1'b1, 3'b011, 1'b1);
            else                cyc(1'b1, 1'b0, 3'b000, 1'b0);
        end
        // constrained random: gappy enables, occasional trim writes
        for (int i = 0; i < 40000; i++) begin
            logic e, w;
            logic [2:0] d;
            e = (($urandom % 5) != 0);
            w = (($urandom % 250) == 0);
            d = 3'($urandom % 8);
            cyc(e, w, d, 1'b0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule